// File: doc/BRIEF.md
# Pipelined Binary Adaptive Arithmetic Encoder

The block turns a stream of (context, decision) pairs into a compressed byte stream. It uses a table-driven adaptive binary arithmetic coder. Each of 19 contexts keeps its own probability state and its own more-probable-symbol (MPS) sense. Carries out of the code register are absorbed by bit stuffing after any 0xFF byte, so a carry never has to travel back more than one byte. A flush command ends a code block: it terminates the code word, pushes out the remaining bytes, and returns every state to its start value for the next block.

The work is split over four stages. The first looks up the context state. The second updates the interval and picks the renormalisation shift. The third adds into the low 16 bits of the code register and shifts them. The fourth adds the carry into the high 12 bits, shifts them and forms the bytes. When the same context arrives on two cycles in a row, the stage-2 result is forwarded to stage 1, so no stall is needed. One pair or flush is taken per cycle. Bytes leave on a three-lane output with a valid mask.

Top module: `mq_pipe_enc`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_vld_o` is 0. The coder starts with interval 0x8000, code register 0 and 12 free bit positions.
- R2: At reset and after each flush, every context has MPS sense 0. Context 0 starts in probability state 4, context 17 in state 3, context 18 in state 46, and all others in state 0.
- R3: Coding an MPS changes the state to its MPS successor only when renormalisation occurs. Coding an LPS always moves the state to its LPS successor, and it inverts the MPS sense when that state's switch bit is 1.
- R4: An MPS takes interval A−Qe and an LPS takes Qe. The two are exchanged when A−Qe < Qe. The interval is then shifted left until bit 15 is set, so it always lies in 0x8000..0xFFFF.
- R5: Pairs on the same context on consecutive cycles give the same bytes as the same pairs with idle cycles between them.
- R6: A byte is formed when the free-bit count reaches zero. The count is reloaded with 8, or with 7 when the byte held before was 0xFF. A byte that follows an emitted 0xFF is below 0x90.
- R7: A carry out of the code register increments the one buffered byte that has not yet been emitted.
- R8: A flush (`in_valid_i` and `in_flush_i`) terminates the code word by setting the lowest possible bits, emits two more bytes, and emits the last buffered byte unless it is 0xFF. The next pair may arrive in the cycle right after the flush.
- R9: Bytes leave in stream order in lanes 0, 1, 2 (bits 7:0 first). The valid mask is one of 000, 001, 011 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pair or flush is present |
| in_ready_o | output | 1 | Always 1: one item taken per cycle |
| in_ctx_i | input | 5 | Context number, 0..18 |
| in_bit_i | input | 1 | Decision to code |
| in_flush_i | input | 1 | With in_valid_i: end the code block |
| out_byte_o | output | 24 | Up to three bytes, lane 0 in bits 7:0 |
| out_vld_o | output | 3 | Valid mask per lane |

## Verification
Two events can fall in the same cycle. One is a context-state update in stage 2 while stage 1 reads the same context. The other is a flush token that resets the context table while a pair from the next block is being looked up. The bench provokes both with long runs of pairs on one or two contexts sent back to back, and with a flush followed at once by pairs on the context used just before it. It also replays one sequence with idle gaps. Every byte is judged against a bit-serial reference coder that runs in the bench.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int A_W   = 16;
  localparam int LO_W  = 16;
  localparam int HI_W  = 12;
  localparam int IDX_W = 6;
  localparam int LANES = 3;

  typedef struct packed {
    logic [A_W-1:0]   qe;
    logic [IDX_W-1:0] nmps;
    logic [IDX_W-1:0] nlps;
    logic             sw;
  } prob_t;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [3:0]      ct;
    logic [7:0]      b;
    logic            bh;
    logic            emit;
    logic [7:0]      ob;
  } bo_t;

  function automatic prob_t prob_lookup(input logic [IDX_W-1:0] i);
    prob_t p;
    case (i)
      6'd0:  p = '{16'h5601, 6'd1,  6'd1,  1'b1};
      6'd1:  p = '{16'h3401, 6'd2,  6'd6,  1'b0};
      6'd2:  p = '{16'h1801, 6'd3,  6'd9,  1'b0};
      6'd3:  p = '{16'h0AC1, 6'd4,  6'd12, 1'b0};
      6'd4:  p = '{16'h0521, 6'd5,  6'd29, 1'b0};
      6'd5:  p = '{16'h0221, 6'd38, 6'd33, 1'b0};
      6'd6:  p = '{16'h5601, 6'd7,  6'd6,  1'b1};
      6'd7:  p = '{16'h5401, 6'd8,  6'd14, 1'b0};
      6'd8:  p = '{16'h4801, 6'd9,  6'd14, 1'b0};
      6'd9:  p = '{16'h3801, 6'd10, 6'd14, 1'b0};
      6'd10: p = '{16'h3001, 6'd11, 6'd17, 1'b0};
      6'd11: p = '{16'h2401, 6'd12, 6'd18, 1'b0};
      6'd12: p = '{16'h1C01, 6'd13, 6'd20, 1'b0};
      6'd13: p = '{16'h1601, 6'd29, 6'd21, 1'b0};
      6'd14: p = '{16'h5601, 6'd15, 6'd14, 1'b1};
      6'd15: p = '{16'h5401, 6'd16, 6'd14, 1'b0};
      6'd16: p = '{16'h5101, 6'd17, 6'd15, 1'b0};
      6'd17: p = '{16'h4801, 6'd18, 6'd16, 1'b0};
      6'd18: p = '{16'h3801, 6'd19, 6'd17, 1'b0};
      6'd19: p = '{16'h3401, 6'd20, 6'd18, 1'b0};
      6'd20: p = '{16'h3001, 6'd21, 6'd19, 1'b0};
      6'd21: p = '{16'h2801, 6'd22, 6'd19, 1'b0};
      6'd22: p = '{16'h2401, 6'd23, 6'd20, 1'b0};
      6'd23: p = '{16'h2201, 6'd24, 6'd21, 1'b0};
      6'd24: p = '{16'h1C01, 6'd25, 6'd22, 1'b0};
      6'd25: p = '{16'h1801, 6'd26, 6'd23, 1'b0};
      6'd26: p = '{16'h1601, 6'd27, 6'd24, 1'b0};
      6'd27: p = '{16'h1401, 6'd28, 6'd25, 1'b0};
      6'd28: p = '{16'h1201, 6'd29, 6'd26, 1'b0};
      6'd29: p = '{16'h1101, 6'd30, 6'd27, 1'b0};
      6'd30: p = '{16'h0AC1, 6'd31, 6'd28, 1'b0};
      6'd31: p = '{16'h09C1, 6'd32, 6'd29, 1'b0};
      6'd32: p = '{16'h08A1, 6'd33, 6'd30, 1'b0};
      6'd33: p = '{16'h0521, 6'd34, 6'd31, 1'b0};
      6'd34: p = '{16'h0441, 6'd35, 6'd32, 1'b0};
      6'd35: p = '{16'h02A1, 6'd36, 6'd33, 1'b0};
      6'd36: p = '{16'h0221, 6'd37, 6'd34, 1'b0};
      6'd37: p = '{16'h0141, 6'd38, 6'd35, 1'b0};
      6'd38: p = '{16'h0111, 6'd39, 6'd36, 1'b0};
      6'd39: p = '{16'h0085, 6'd40, 6'd37, 1'b0};
      6'd40: p = '{16'h0049, 6'd41, 6'd38, 1'b0};
      6'd41: p = '{16'h0025, 6'd42, 6'd39, 1'b0};
      6'd42: p = '{16'h0015, 6'd43, 6'd40, 1'b0};
      6'd43: p = '{16'h0009, 6'd44, 6'd41, 1'b0};
      6'd44: p = '{16'h0005, 6'd45, 6'd42, 1'b0};
      6'd45: p = '{16'h0001, 6'd45, 6'd43, 1'b0};
      default: p = '{16'h5601, 6'd46, 6'd46, 1'b0};
    endcase
    return p;
  endfunction

  // R2 start states
  function automatic logic [IDX_W-1:0] ctx_init(input int c);
    if (c == 0)  return 6'd4;
    if (c == 17) return 6'd3;
    if (c == 18) return 6'd46;
    return 6'd0;
  endfunction

  function automatic logic [3:0] lzc16(input logic [A_W-1:0] v);
    logic [3:0] n;
    logic       hit;
    n   = '0;
    hit = 1'b0;
    for (int i = A_W-1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n = n + 4'd1;
      end
    end
    return n;
  endfunction

  // one byte formed from the high code bits, with stuffing and carry
  function automatic bo_t byte_out(input logic [HI_W-1:0] hi, input logic [7:0] b,
                                   input logic bh);
    bo_t r;
    logic [7:0] binc;
    r.emit = bh;
    r.bh   = 1'b1;
    r.ob   = b;
    r.hi   = hi;
    binc   = b + 8'd1;
    if (b == 8'hFF) begin
      r.b  = hi[11:4];
      r.hi = {8'd0, hi[3:0]};
      r.ct = 4'd7;
    end else if (!hi[11]) begin
      r.b  = hi[10:3];
      r.hi = {9'd0, hi[2:0]};
      r.ct = 4'd8;
    end else begin
      r.ob = binc;
      if (binc == 8'hFF) begin
        r.b  = {1'b0, hi[10:4]};
        r.hi = {8'd0, hi[3:0]};
        r.ct = 4'd7;
      end else begin
        r.b  = hi[10:3];
        r.hi = {9'd0, hi[2:0]};
        r.ct = 4'd8;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mq_ctx_stage.sv
module mq_ctx_stage
  import mq_pkg::*;
#(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             p1_vld_i,
  input  logic             p1_flush_i,
  input  logic [CTX_W-1:0] p1_ctx_i,
  input  logic             p1_bit_i,
  output logic             p3_vld_o,
  output logic             p3_flush_o,
  output logic [A_W-1:0]   p3_add_o,
  output logic [3:0]       p3_shift_o,
  output logic [A_W-1:0]   p3_a_o
);
  localparam int SLOTS = 1 << CTX_W;

  logic [IDX_W-1:0] idx_q [SLOTS];
  logic             mps_q [SLOTS];

  logic             p2_vld, p2_flush, p2_bit, p2_mps;
  logic [CTX_W-1:0] p2_ctx;
  logic [IDX_W-1:0] p2_idx;
  prob_t            p2_prob;
  logic [A_W-1:0]   a_q;

  // stage 1: lookup with look-ahead from stage 2
  logic             fwd, clr;
  logic [IDX_W-1:0] s1_idx, nxt_idx;
  logic             s1_mps, nxt_mps;

  always_comb begin
    fwd = p2_vld && !p2_flush && (p2_ctx == p1_ctx_i);
    clr = p2_vld && p2_flush;
    if (clr) begin
      s1_idx = ctx_init(int'(p1_ctx_i));
      s1_mps = 1'b0;
    end else if (fwd) begin
      s1_idx = nxt_idx;
      s1_mps = nxt_mps;
    end else begin
      s1_idx = idx_q[p1_ctx_i];
      s1_mps = mps_q[p1_ctx_i];
    end
  end

  // stage 2: interval update
  logic [A_W-1:0] a_m, a_sel, add;
  logic [3:0]     sh;
  always_comb begin
    a_m     = a_q - p2_prob.qe;
    a_sel   = a_m;
    add     = p2_prob.qe;
    nxt_idx = p2_idx;
    nxt_mps = p2_mps;
    if (p2_bit == p2_mps) begin
      if (!a_m[A_W-1]) begin
        nxt_idx = p2_prob.nmps;
        if (a_m < p2_prob.qe) begin
          a_sel = p2_prob.qe;
          add   = '0;
        end
      end
    end else begin
      nxt_idx = p2_prob.nlps;
      nxt_mps = p2_mps ^ p2_prob.sw;
      if (!(a_m < p2_prob.qe)) begin
        a_sel = p2_prob.qe;
        add   = '0;
      end
    end
    sh = lzc16(a_sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < SLOTS; c++) begin
        idx_q[c] <= ctx_init(c);
        mps_q[c] <= 1'b0;
      end
      p2_vld   <= 1'b0;
      p2_flush <= 1'b0;
      p2_bit   <= 1'b0;
      p2_mps   <= 1'b0;
      p2_ctx   <= '0;
      p2_idx   <= '0;
      p2_prob  <= '0;
      a_q      <= 16'h8000;
      p3_vld_o   <= 1'b0;
      p3_flush_o <= 1'b0;
      p3_add_o   <= '0;
      p3_shift_o <= '0;
      p3_a_o     <= '0;
    end else begin
      p2_vld   <= p1_vld_i;
      p2_flush <= p1_flush_i;
      p2_bit   <= p1_bit_i;
      p2_mps   <= s1_mps;
      p2_ctx   <= p1_ctx_i;
      p2_idx   <= s1_idx;
      p2_prob  <= prob_lookup(s1_idx);
      p3_vld_o   <= p2_vld;
      p3_flush_o <= p2_flush;
      p3_add_o   <= add;
      p3_shift_o <= sh;
      p3_a_o     <= a_q;
      if (p2_vld && p2_flush) begin
        for (int c = 0; c < SLOTS; c++) begin
          idx_q[c] <= ctx_init(c);
          mps_q[c] <= 1'b0;
        end
        a_q <= 16'h8000;
      end else if (p2_vld) begin
        idx_q[p2_ctx] <= nxt_idx;
        mps_q[p2_ctx] <= nxt_mps;
        a_q           <= a_sel << sh;
      end
    end
  end

  // R4
  a_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) a_q[A_W-1]);
endmodule

// File: rtl/mq_low_stage.sv
module mq_low_stage
  import mq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            p3_vld_i,
  input  logic            p3_flush_i,
  input  logic [A_W-1:0]  p3_add_i,
  input  logic [3:0]      p3_shift_i,
  input  logic [A_W-1:0]  p3_a_i,
  output logic            p4_vld_o,
  output logic            p4_flush_o,
  output logic            p4_carry_o,
  output logic [LO_W-1:0] p4_lo_o,
  output logic [3:0]      p4_shift_o
);
  logic [LO_W-1:0] c_lo_q;
  logic [LO_W:0]   sum, tsum;

  assign sum  = {1'b0, c_lo_q} + {1'b0, p3_add_i};
  assign tsum = {1'b0, c_lo_q} + {1'b0, p3_a_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_lo_q     <= '0;
      p4_vld_o   <= 1'b0;
      p4_flush_o <= 1'b0;
      p4_carry_o <= 1'b0;
      p4_lo_o    <= '0;
      p4_shift_o <= '0;
    end else begin
      p4_vld_o   <= p3_vld_i;
      p4_flush_o <= p3_flush_i;
      p4_shift_o <= p3_shift_i;
      if (p3_vld_i && p3_flush_i) begin
        // lowest termination value inside the final interval
        p4_carry_o <= 1'b0;
        p4_lo_o    <= tsum[LO_W] ? 16'hFFFF : 16'h7FFF;
        c_lo_q     <= '0;
      end else if (p3_vld_i) begin
        p4_carry_o <= sum[LO_W];
        p4_lo_o    <= sum[LO_W-1:0];
        c_lo_q     <= sum[LO_W-1:0] << p3_shift_i;
      end else begin
        p4_carry_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mq_high_stage.sv
module mq_high_stage
  import mq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               p4_vld_i,
  input  logic               p4_flush_i,
  input  logic               p4_carry_i,
  input  logic [LO_W-1:0]    p4_lo_i,
  input  logic [3:0]         p4_shift_i,
  output logic [8*LANES-1:0] out_byte_o,
  output logic [LANES-1:0]   out_vld_o
);
  logic [HI_W-1:0] c_hi_q, hi;
  logic [3:0]      ct_q, ct;
  logic [7:0]      b_q, b;
  logic            bh_q, bh;
  logic [HI_W+LO_W-1:0] c28;
  logic [LANES-1:0][7:0] lane;
  logic [LANES-1:0] vld;
  logic [1:0]      n;
  bo_t             r;

  always_comb begin
    hi   = c_hi_q;
    ct   = ct_q;
    b    = b_q;
    bh   = bh_q;
    lane = '0;
    vld  = '0;
    n    = '0;
    c28  = '0;
    r    = '0;
    if (p4_vld_i && !p4_flush_i) begin
      hi = hi + {{(HI_W-1){1'b0}}, p4_carry_i};
      for (int k = 0; k < 15; k++) begin
        if (4'(k) < p4_shift_i) begin
          hi = {hi[HI_W-2:0], p4_lo_i[15-k]};
          ct = ct - 4'd1;
          if (ct == 4'd0) begin
            r  = byte_out(hi, b, bh);
            hi = r.hi; ct = r.ct; b = r.b; bh = r.bh;
            if (r.emit) begin
              lane[n] = r.ob; vld[n] = 1'b1; n = n + 2'd1;
            end
          end
        end
      end
    end else if (p4_vld_i) begin
      c28 = {hi, p4_lo_i} << ct;
      for (int j = 0; j < 2; j++) begin
        r = byte_out(c28[HI_W+LO_W-1:LO_W], b, bh);
        c28[HI_W+LO_W-1:LO_W] = r.hi;
        ct = r.ct; b = r.b; bh = r.bh;
        if (r.emit) begin
          lane[n] = r.ob; vld[n] = 1'b1; n = n + 2'd1;
        end
        if (j == 0) c28 = c28 << ct;
      end
      // R8 trailing 0xFF is dropped
      if (bh && b != 8'hFF) begin
        lane[n] = b; vld[n] = 1'b1;
      end
    end
  end

  // bytes following an emitted 0xFF within a block
  logic stuff_bad, last_ff_q, last_ff;
  always_comb begin
    stuff_bad = 1'b0;
    last_ff   = last_ff_q;
    for (int i = 0; i < LANES; i++) begin
      if (vld[i]) begin
        if (last_ff && lane[i] >= 8'h90) stuff_bad = 1'b1;
        last_ff = (lane[i] == 8'hFF);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_hi_q     <= '0;
      ct_q       <= 4'd12;
      b_q        <= '0;
      bh_q       <= 1'b0;
      last_ff_q  <= 1'b0;
      out_byte_o <= '0;
      out_vld_o  <= '0;
    end else begin
      out_byte_o <= lane;
      out_vld_o  <= vld;
      if (p4_vld_i && p4_flush_i) begin
        c_hi_q    <= '0;
        ct_q      <= 4'd12;
        b_q       <= '0;
        bh_q      <= 1'b0;
        last_ff_q <= 1'b0;
      end else begin
        c_hi_q    <= hi;
        ct_q      <= ct;
        b_q       <= b;
        bh_q      <= bh;
        last_ff_q <= last_ff;
      end
    end
  end

  // R6
  ct_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ct_q != 4'd0) && (ct_q <= 4'd12));
  // R6
  stuff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !stuff_bad);
endmodule

// File: rtl/mq_pipe_enc.sv
module mq_pipe_enc
  import mq_pkg::*;
#(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [CTX_W-1:0]   in_ctx_i,
  input  logic               in_bit_i,
  input  logic               in_flush_i,
  output logic [8*LANES-1:0] out_byte_o,
  output logic [LANES-1:0]   out_vld_o
);
  logic             p1_vld, p1_flush, p1_bit;
  logic [CTX_W-1:0] p1_ctx;
  logic             p3_vld, p3_flush;
  logic [A_W-1:0]   p3_add, p3_a;
  logic [3:0]       p3_shift, p4_shift;
  logic             p4_vld, p4_flush, p4_carry;
  logic [LO_W-1:0]  p4_lo;

  // R1
  assign in_ready_o = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_vld   <= 1'b0;
      p1_flush <= 1'b0;
      p1_bit   <= 1'b0;
      p1_ctx   <= '0;
    end else begin
      p1_vld   <= in_valid_i;
      p1_flush <= in_valid_i && in_flush_i;
      p1_bit   <= in_bit_i;
      p1_ctx   <= in_ctx_i;
    end
  end

  mq_ctx_stage #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) i_ctx (
    .clk_i, .rst_ni,
    .p1_vld_i(p1_vld), .p1_flush_i(p1_flush), .p1_ctx_i(p1_ctx), .p1_bit_i(p1_bit),
    .p3_vld_o(p3_vld), .p3_flush_o(p3_flush), .p3_add_o(p3_add),
    .p3_shift_o(p3_shift), .p3_a_o(p3_a)
  );

  mq_low_stage i_low (
    .clk_i, .rst_ni,
    .p3_vld_i(p3_vld), .p3_flush_i(p3_flush), .p3_add_i(p3_add),
    .p3_shift_i(p3_shift), .p3_a_i(p3_a),
    .p4_vld_o(p4_vld), .p4_flush_o(p4_flush), .p4_carry_o(p4_carry),
    .p4_lo_o(p4_lo), .p4_shift_o(p4_shift)
  );

  mq_high_stage i_high (
    .clk_i, .rst_ni,
    .p4_vld_i(p4_vld), .p4_flush_i(p4_flush), .p4_carry_i(p4_carry),
    .p4_lo_i(p4_lo), .p4_shift_i(p4_shift),
    .out_byte_o, .out_vld_o
  );

  // R9
  lane_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == 3'b000 || out_vld_o == 3'b001 || out_vld_o == 3'b011 || out_vld_o == 3'b111);
endmodule

// File: tb/test_mq_pipe_enc.sv
module test_mq_pipe_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_bit = 1'b0, in_flush = 1'b0;
  logic [4:0]  in_ctx = '0;
  logic        in_ready;
  logic [23:0] out_byte;
  logic [2:0]  out_vld;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mq_pipe_enc i_mq_pipe_enc (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_ctx_i(in_ctx), .in_bit_i(in_bit), .in_flush_i(in_flush),
    .out_byte_o(out_byte), .out_vld_o(out_vld)
  );

  // reference coder, bit-serial
  logic [15:0] m_a;
  logic [31:0] m_c;
  int          m_ct;
  logic [7:0]  m_b;
  bit          m_bh;
  int          m_idx [19];
  bit          m_mps [19];
  logic [7:0]  exp_q[$];
  logic [7:0]  got_q[$];

  function automatic logic [28:0] tb_prob(input int i);
    case (i)
      0: return {16'h5601, 6'd1, 6'd1, 1'b1};    1: return {16'h3401, 6'd2, 6'd6, 1'b0};
      2: return {16'h1801, 6'd3, 6'd9, 1'b0};    3: return {16'h0AC1, 6'd4, 6'd12, 1'b0};
      4: return {16'h0521, 6'd5, 6'd29, 1'b0};   5: return {16'h0221, 6'd38, 6'd33, 1'b0};
      6: return {16'h5601, 6'd7, 6'd6, 1'b1};    7: return {16'h5401, 6'd8, 6'd14, 1'b0};
      8: return {16'h4801, 6'd9, 6'd14, 1'b0};   9: return {16'h3801, 6'd10, 6'd14, 1'b0};
      10: return {16'h3001, 6'd11, 6'd17, 1'b0}; 11: return {16'h2401, 6'd12, 6'd18, 1'b0};
      12: return {16'h1C01, 6'd13, 6'd20, 1'b0}; 13: return {16'h1601, 6'd29, 6'd21, 1'b0};
      14: return {16'h5601, 6'd15, 6'd14, 1'b1}; 15: return {16'h5401, 6'd16, 6'd14, 1'b0};
      16: return {16'h5101, 6'd17, 6'd15, 1'b0}; 17: return {16'h4801, 6'd18, 6'd16, 1'b0};
      18: return {16'h3801, 6'd19, 6'd17, 1'b0}; 19: return {16'h3401, 6'd20, 6'd18, 1'b0};
      20: return {16'h3001, 6'd21, 6'd19, 1'b0}; 21: return {16'h2801, 6'd22, 6'd19, 1'b0};
      22: return {16'h2401, 6'd23, 6'd20, 1'b0}; 23: return {16'h2201, 6'd24, 6'd21, 1'b0};
      24: return {16'h1C01, 6'd25, 6'd22, 1'b0}; 25: return {16'h1801, 6'd26, 6'd23, 1'b0};
      26: return {16'h1601, 6'd27, 6'd24, 1'b0}; 27: return {16'h1401, 6'd28, 6'd25, 1'b0};
      28: return {16'h1201, 6'd29, 6'd26, 1'b0}; 29: return {16'h1101, 6'd30, 6'd27, 1'b0};
      30: return {16'h0AC1, 6'd31, 6'd28, 1'b0}; 31: return {16'h09C1, 6'd32, 6'd29, 1'b0};
      32: return {16'h08A1, 6'd33, 6'd30, 1'b0}; 33: return {16'h0521, 6'd34, 6'd31, 1'b0};
      34: return {16'h0441, 6'd35, 6'd32, 1'b0}; 35: return {16'h02A1, 6'd36, 6'd33, 1'b0};
      36: return {16'h0221, 6'd37, 6'd34, 1'b0}; 37: return {16'h0141, 6'd38, 6'd35, 1'b0};
      38: return {16'h0111, 6'd39, 6'd36, 1'b0}; 39: return {16'h0085, 6'd40, 6'd37, 1'b0};
      40: return {16'h0049, 6'd41, 6'd38, 1'b0}; 41: return {16'h0025, 6'd42, 6'd39, 1'b0};
      42: return {16'h0015, 6'd43, 6'd40, 1'b0}; 43: return {16'h0009, 6'd44, 6'd41, 1'b0};
      44: return {16'h0005, 6'd45, 6'd42, 1'b0}; 45: return {16'h0001, 6'd45, 6'd43, 1'b0};
      default: return {16'h5601, 6'd46, 6'd46, 1'b0};
    endcase
  endfunction

  task automatic mdl_init();
    m_a = 16'h8000; m_c = 0; m_ct = 12; m_b = 0; m_bh = 0;
    for (int c = 0; c < 19; c++) begin
      m_idx[c] = (c == 0) ? 4 : (c == 17) ? 3 : (c == 18) ? 46 : 0;  // R2
      m_mps[c] = 0;
    end
  endtask

  task automatic mdl_emit(input logic [7:0] v);
    if (m_bh) exp_q.push_back(v);
    m_bh = 1;
  endtask

  task automatic mdl_byteout();  // R6 R7
    if (m_b == 8'hFF) begin
      mdl_emit(m_b); m_b = 8'(m_c >> 20); m_c &= 32'hFFFFF; m_ct = 7;
    end else if (m_c < 32'h8000000) begin
      mdl_emit(m_b); m_b = 8'(m_c >> 19); m_c &= 32'h7FFFF; m_ct = 8;
    end else begin
      m_b = m_b + 8'd1;
      if (m_b == 8'hFF) begin
        m_c &= 32'h7FFFFFF; mdl_emit(m_b); m_b = 8'(m_c >> 20); m_c &= 32'hFFFFF; m_ct = 7;
      end else begin
        mdl_emit(m_b); m_b = 8'(m_c >> 19); m_c &= 32'h7FFFF; m_ct = 8;
      end
    end
  endtask

  task automatic mdl_renorm();
    do begin
      m_a = m_a << 1; m_c = m_c << 1; m_ct--;
      if (m_ct == 0) mdl_byteout();
    end while (!m_a[15]);
  endtask

  task automatic mdl_code(input int cx, input bit d);  // R3 R4
    logic [28:0] p;
    logic [15:0] qe;
    p  = tb_prob(m_idx[cx]);
    qe = p[28:13];
    m_a = m_a - qe;
    if (d == m_mps[cx]) begin
      if (!m_a[15]) begin
        if (m_a < qe) m_a = qe; else m_c += 32'(qe);
        m_idx[cx] = int'(p[12:7]);
        mdl_renorm();
      end else m_c += 32'(qe);
    end else begin
      if (m_a < qe) m_c += 32'(qe); else m_a = qe;
      if (p[0]) m_mps[cx] = ~m_mps[cx];
      m_idx[cx] = int'(p[6:1]);
      mdl_renorm();
    end
  endtask

  task automatic mdl_flush();  // R8
    logic [31:0] t;
    t = m_c + 32'(m_a);
    m_c = m_c | 32'hFFFF;
    if (m_c >= t) m_c = m_c - 32'h8000;
    m_c = m_c << m_ct; mdl_byteout();
    m_c = m_c << m_ct; mdl_byteout();
    if (m_b != 8'hFF && m_bh) exp_q.push_back(m_b);
    mdl_init();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++)
        if (out_vld[i]) got_q.push_back(out_byte[8*i +: 8]);
    end
  end

  task automatic put(input int cx, input bit d, input bit fl, input int gap);
    in_valid = 1; in_ctx = cx[4:0]; in_bit = d; in_flush = fl;
    @(negedge clk);
    in_valid = 0; in_flush = 0;
    repeat (gap) @(negedge clk);
    if (fl) mdl_flush(); else mdl_code(cx, d);
  endtask

  task automatic check_block(input string req);
    repeat (10) @(negedge clk);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s byte count: got %0d expected %0d", req, got_q.size(), exp_q.size());
    end
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      checks++;
      if (got_q[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s byte %0d: got %02h expected %02h", req, i, got_q[i], exp_q[i]);
      end
    end
    got_q.delete(); exp_q.delete();
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mdl_init();
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (in_ready !== 1'b1) begin errors++; $display("FAIL R1 ready: got %b expected 1", in_ready); end
    checks++;
    if (out_vld !== 3'b000) begin errors++; $display("FAIL R1 out_vld: got %b expected 000", out_vld); end
    rst_n = 1'b1;
    @(negedge clk);

    // R8 empty block
    put(0, 0, 1, 0);
    check_block("R8");

    // R2 uniform and run-length contexts from start state
    for (int i = 0; i < 64; i++) put(18, 0, 0, 0);
    for (int i = 0; i < 40; i++) put(17, i % 5 == 0, 0, 0);
    for (int i = 0; i < 40; i++) put(0, i % 7 == 3, 0, 0);
    put(0, 0, 1, 0);
    check_block("R2");

    // R3 LPS streak in switch states
    for (int i = 0; i < 60; i++) put(5, i % 3 != 0, 0, 0);
    put(0, 0, 1, 0);
    check_block("R3");

    // R5 back to back on two contexts
    for (int i = 0; i < 600; i++) begin
      lfsr = step(lfsr);
      put(int'(lfsr[0]), lfsr[3] & lfsr[5], 0, 0);
    end
    put(0, 0, 1, 0);
    check_block("R5");

    // R5 same pattern shape with idle gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = step(lfsr);
      put(int'(lfsr[0]), lfsr[3] & lfsr[5], 0, int'(lfsr[8:7]));
    end
    put(0, 0, 1, 0);
    check_block("R5");

    // R4 R6 R7 all contexts, mixed skew
    for (int i = 0; i < 3000; i++) begin
      lfsr = step(lfsr);
      put(int'(lfsr[4:0]) % 19, (i % 400 < 200) ? lfsr[9] : (lfsr[9] & lfsr[11] & lfsr[2]), 0, 0);
    end
    put(0, 0, 1, 0);
    check_block("R7");

    // R6 near-uniform decisions
    for (int i = 0; i < 2000; i++) begin
      lfsr = step(lfsr);
      put(18, lfsr[6], 0, 0);
    end
    put(0, 0, 1, 0);
    check_block("R6");

    // R8 flush followed at once by the same context, then R9 lane order
    for (int i = 0; i < 30; i++) put(3, i % 4 == 1, 0, 0);
    put(0, 0, 1, 0);
    for (int i = 0; i < 30; i++) put(3, i % 4 == 2, 0, 0);
    put(0, 0, 1, 0);
    check_block("R9");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule